// File: doc/BRIEF.md
# Framebuffer Block Compression Controller

This controller sits between a multisample pixel writer and a burst-based external memory. It moves one 2x2 pixel block per request. Each pixel carries four samples, and each sample is 64 bits: 32 bits of colour and 32 bits of depth/stencil. Memory is reached in 32-byte bursts (256 bits), one burst in flight at a time.

On a block write, the controller checks whether every pixel's four samples are identical.

- If they are, the block is stored compressed: one sample per pixel, in a single burst.
- Otherwise it is stored expanded: the samples of each pixel, pixel after pixel, in four bursts.

A one-bit state per block is held in on-chip flops. A read consults that bit before touching memory, so the burst count is fixed before the first request goes out. The read then rebuilds the full 16-sample block for the requester.

Top module: `fb_block_compressor`

## Requirements
- R1: After reset, `reqReady` is 1, `memReqValid` is 0 and `rspValid` is 0.
- R2: Sample s of pixel p occupies `reqData[(4p+s)*64 +: 64]`, with colour in the low 32 bits. A write whose pixels each hold four equal samples issues exactly one memory write at address `block*4`. Its data places sample 0 of pixel p at bits `[p*64 +: 64]`.
- R3: A write in which any pixel holds differing samples issues four memory writes, at addresses `block*4+b` for b = 0..3 in ascending order. Burst b carries pixel b's samples 0..3 at bits `[s*64 +: 64]`.
- R4: A write records its block's state: 1 when some pixel's samples differ, 0 when all pixels are uniform. `rspExpanded` reports this value with the completion pulse. A read accepted in the same cycle that a write to the same block completes sees the newly written state.
- R5: A read of a block in state 0 issues one memory read at `block*4`. Each pixel's 64-bit word is copied to all four of that pixel's sample positions in `rspData`.
- R6: A read of a block in state 1 issues four memory reads at `block*4+b`, ascending. Burst b fills pixel b's samples in `rspData`.
- R7: A new memory request is not raised while a read burst's response is still awaited.
- R8: While `memReqValid` is high and `memReqReady` is low, the request stays raised with unchanged address and direction.
- R9: `reqReady` is high only when idle or in the completion cycle. `rspValid` is a single-cycle pulse, once per accepted request.
- R10: A block never written since reset reads as state 0, with one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Block request present |
| reqReady | output | 1 | Request accepted this cycle when high |
| reqWrite | input | 1 | 1 = block write, 0 = block read |
| reqBlock | input | 6 | Block index |
| reqData | input | 1024 | Sixteen samples of the block to write |
| rspValid | output | 1 | Completion pulse |
| rspExpanded | output | 1 | Stored state of the block handled |
| rspData | output | 1024 | Rebuilt samples on read completion |
| memReqValid | output | 1 | Burst request to memory |
| memReqReady | input | 1 | Memory accepts the burst request |
| memReqWrite | output | 1 | 1 = burst write, 0 = burst read |
| memAddr | output | 8 | Burst address in 32-byte units |
| memWData | output | 256 | Burst write data |
| memRspValid | input | 1 | Read burst data present |
| memRspData | input | 256 | Read burst data |

## Verification
Two events can land in the same cycle:

- a write's completion, which updates the block-state flops;
- acceptance of a read of that same block, which latches the state lookup.

The bench provokes this by presenting the read while the write is still in flight, so the controller accepts it in the write's completion cycle. Both uniform-after-expanded and expanded-after-uniform orders are covered. The outcome is judged at the ports, by the number and addresses of memory read bursts, by `rspExpanded`, and by the rebuilt samples. A stale lookup would show as one burst where four are due, or the reverse.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  // Strobes from the sequencer to the sample datapath.
  typedef struct packed {
    logic load;      // latch a new request block
    logic capture;   // a read burst is present on memRspData
    logic expanded;  // current block uses the four-burst layout
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } fbcState_t;

endpackage

// File: rtl/fbc_flag_store.sv
module fbc_flag_store #(
  parameter int BLK_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdEn,
  input  logic [BLK_W-1:0] rdAddr,
  output logic             rdData,
  input  logic             wrEn,
  input  logic [BLK_W-1:0] wrAddr,
  input  logic             wrData
);

  localparam int BLOCKS = 1 << BLK_W;

  logic [BLOCKS-1:0] flags;
  logic              collide;

  assign collide = wrEn && rdEn && (wrAddr == rdAddr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (wrEn) begin
      flags[wrAddr] <= wrData;
    end
  end

  // Registered lookup; a same-cycle update of the same entry is forwarded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData <= 1'b0;
    end else if (rdEn) begin
      rdData <= collide ? wrData : flags[rdAddr];
    end
  end

  // R4: a lookup racing an update of the same entry returns the new value
  p_flag_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && rdEn && (wrAddr == rdAddr)) |=> (rdData == $past(wrData)));

endmodule

// File: rtl/fbc_datapath.sv
module fbc_datapath
  import fbc_pkg::*;
#(
  parameter int PIX     = 4,
  parameter int SPP     = 4,
  parameter int COLOR_W = 32,
  parameter int DEPTH_W = 32,
  parameter int IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  dpStrobe_t                       ctl,
  input  logic [IDX_W-1:0]                burstIdx,
  input  logic [PIX*SPP*(COLOR_W+DEPTH_W)-1:0] reqData,
  input  logic [PIX*(COLOR_W+DEPTH_W)-1:0]     memRspData,
  output logic [PIX*(COLOR_W+DEPTH_W)-1:0]     memWData,
  output logic [PIX*SPP*(COLOR_W+DEPTH_W)-1:0] rspData,
  output logic                            uniformQ
);

  localparam int SAMPLE_W    = COLOR_W + DEPTH_W;
  localparam int BURST_W     = PIX * SAMPLE_W;
  localparam int BLOCK_W     = PIX * SPP * SAMPLE_W;
  localparam int FULL_BURSTS = BLOCK_W / BURST_W;

  logic [BLOCK_W-1:0]         blockQ;
  logic [BLOCK_W-1:0]         spreadWord;
  logic [BURST_W-1:0]         packWord;
  logic [BURST_W-1:0]         chunks [FULL_BURSTS];
  logic [PIX-1:0][SPP-1:0]    sameAsFirst;
  logic                       uniformNow;

  // Per-pixel uniformity of the incoming block.
  for (genvar p = 0; p < PIX; p++) begin : g_uni
    for (genvar s = 0; s < SPP; s++) begin : g_smp
      if (s == 0) begin : g_first
        assign sameAsFirst[p][s] = 1'b1;
      end else begin : g_rest
        assign sameAsFirst[p][s] =
          (reqData[(p*SPP+s)*SAMPLE_W +: SAMPLE_W] == reqData[p*SPP*SAMPLE_W +: SAMPLE_W]);
      end
    end
  end
  assign uniformNow = &sameAsFirst;

  // Compressed burst: sample 0 of each pixel, pixel-indexed.
  for (genvar p = 0; p < PIX; p++) begin : g_pack
    assign packWord[p*SAMPLE_W +: SAMPLE_W] = blockQ[p*SPP*SAMPLE_W +: SAMPLE_W];
  end

  // Expansion of a compressed burst into every sample slot.
  for (genvar p = 0; p < PIX; p++) begin : g_spread
    for (genvar s = 0; s < SPP; s++) begin : g_copy
      assign spreadWord[(p*SPP+s)*SAMPLE_W +: SAMPLE_W] = memRspData[p*SAMPLE_W +: SAMPLE_W];
    end
  end

  // Expanded layout: the pixel-major sample stream cut into bursts.
  for (genvar b = 0; b < FULL_BURSTS; b++) begin : g_chunk
    assign chunks[b] = blockQ[b*BURST_W +: BURST_W];
  end

  assign memWData = ctl.expanded ? chunks[burstIdx] : packWord;
  assign rspData  = blockQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blockQ   <= '0;
      uniformQ <= 1'b0;
    end else if (ctl.load) begin
      blockQ   <= reqData;
      uniformQ <= uniformNow;
    end else if (ctl.capture) begin
      if (ctl.expanded) begin
        for (int b = 0; b < FULL_BURSTS; b++) begin
          if (IDX_W'(b) == burstIdx) begin
            blockQ[b*BURST_W +: BURST_W] <= memRspData;
          end
        end
      end else begin
        blockQ <= spreadWord;
      end
    end
  end

  // R5: after a compressed capture every sample of a pixel equals its first
  for (genvar p = 0; p < PIX; p++) begin : g_chk
    for (genvar s = 1; s < SPP; s++) begin : g_s
      p_expand_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.capture && !ctl.expanded) |=>
          (rspData[(p*SPP+s)*SAMPLE_W +: SAMPLE_W] == rspData[p*SPP*SAMPLE_W +: SAMPLE_W]));
    end
  end

endmodule

// File: rtl/fbc_control.sv
module fbc_control
  import fbc_pkg::*;
#(
  parameter int BLK_W       = 6,
  parameter int IDX_W       = 2,
  parameter int FULL_BURSTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [BLK_W-1:0]       reqBlock,
  output logic                   rspValid,
  output logic                   rspExpanded,
  output logic                   memReqValid,
  input  logic                   memReqReady,
  output logic                   memReqWrite,
  output logic [BLK_W+IDX_W-1:0] memAddr,
  input  logic                   memRspValid,
  input  logic                   uniformQ,
  output dpStrobe_t              ctl,
  output logic [IDX_W-1:0]       burstIdx,
  output logic                   flagRdEn,
  output logic [BLK_W-1:0]       flagRdAddr,
  input  logic                   flagRdData,
  output logic                   flagWrEn,
  output logic [BLK_W-1:0]       flagWrAddr,
  output logic                   flagWrData
);

  fbcState_t        state, stateNext;
  logic             opWrite;
  logic [BLK_W-1:0] blkQ;
  logic             expandedQ;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] lastIdx;
  logic             accept;
  logic             memFire;
  logic             atLast;

  assign reqReady = (state == ST_IDLE) || (state == ST_DONE);
  assign accept   = reqValid && reqReady;
  assign lastIdx  = expandedQ ? IDX_W'(FULL_BURSTS - 1) : '0;
  assign atLast   = (idxQ == lastIdx);

  assign memReqValid = (state == ST_ISSUE);
  assign memReqWrite = opWrite;
  assign memAddr     = {blkQ, idxQ};
  assign memFire     = memReqValid && memReqReady;

  assign rspValid    = (state == ST_DONE);
  assign rspExpanded = expandedQ;

  assign flagRdEn   = accept;
  assign flagRdAddr = reqBlock;
  assign flagWrEn   = (state == ST_DONE) && opWrite;
  assign flagWrAddr = blkQ;
  assign flagWrData = expandedQ;

  assign ctl.load     = accept;
  assign ctl.capture  = (state == ST_WAIT) && memRspValid;
  assign ctl.expanded = expandedQ;
  assign burstIdx     = idxQ;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (accept) stateNext = ST_LOOKUP;
      ST_LOOKUP: stateNext = ST_ISSUE;
      ST_ISSUE:  if (memFire) begin
                   if (!opWrite)   stateNext = ST_WAIT;
                   else if (atLast) stateNext = ST_DONE;
                 end
      ST_WAIT:   if (memRspValid) stateNext = atLast ? ST_DONE : ST_ISSUE;
      ST_DONE:   stateNext = accept ? ST_LOOKUP : ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      opWrite   <= 1'b0;
      blkQ      <= '0;
      expandedQ <= 1'b0;
      idxQ      <= '0;
    end else begin
      state <= stateNext;
      if (accept) begin
        opWrite <= reqWrite;
        blkQ    <= reqBlock;
      end
      if (state == ST_LOOKUP) begin
        expandedQ <= opWrite ? !uniformQ : flagRdData;
        idxQ      <= '0;
      end else if ((state == ST_ISSUE) && memFire && opWrite && !atLast) begin
        idxQ <= idxQ + 1'b1;
      end else if ((state == ST_WAIT) && memRspValid && !atLast) begin
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  // Checker-side count of bursts moved for the request in flight.
  logic [IDX_W:0] beatCount;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beatCount <= '0;
    else if (accept)  beatCount <= '0;
    else if (memFire) beatCount <= beatCount + 1'b1;
  end

  // R7: a read burst blocks further requests until its data returns
  p_single_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (memFire && !memReqWrite) |=> !memReqValid);

  // R8: a stalled request holds
  p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memAddr) && $stable(memReqWrite)));

  // R2, R3, R5, R6: burst count at completion matches the stored state
  p_burst_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> (beatCount == (rspExpanded ? (IDX_W+1)'(FULL_BURSTS) : (IDX_W+1)'(1))));

  // R9: completion is a one-cycle pulse
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

endmodule

// File: rtl/fb_block_compressor.sv
module fb_block_compressor
  import fbc_pkg::*;
#(
  parameter int BLK_W   = 6,
  parameter int PIX     = 4,
  parameter int SPP     = 4,
  parameter int COLOR_W = 32,
  parameter int DEPTH_W = 32
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      reqValid,
  output logic                                      reqReady,
  input  logic                                      reqWrite,
  input  logic [BLK_W-1:0]                          reqBlock,
  input  logic [PIX*SPP*(COLOR_W+DEPTH_W)-1:0]      reqData,
  output logic                                      rspValid,
  output logic                                      rspExpanded,
  output logic [PIX*SPP*(COLOR_W+DEPTH_W)-1:0]      rspData,
  output logic                                      memReqValid,
  input  logic                                      memReqReady,
  output logic                                      memReqWrite,
  output logic [BLK_W+$clog2(SPP)-1:0]              memAddr,
  output logic [PIX*(COLOR_W+DEPTH_W)-1:0]          memWData,
  input  logic                                      memRspValid,
  input  logic [PIX*(COLOR_W+DEPTH_W)-1:0]          memRspData
);

  localparam int SAMPLE_W    = COLOR_W + DEPTH_W;
  localparam int BURST_W     = PIX * SAMPLE_W;
  localparam int BLOCK_W     = PIX * SPP * SAMPLE_W;
  localparam int FULL_BURSTS = BLOCK_W / BURST_W;
  localparam int IDX_W       = $clog2(SPP);

  initial begin
    assert (FULL_BURSTS == SPP && SPP > 1 && (SPP & (SPP - 1)) == 0)
      else $error("sample count per pixel must be a power of two above one");
  end

  dpStrobe_t        ctl;
  logic [IDX_W-1:0] burstIdx;
  logic             uniformQ;
  logic             flagRdEn, flagRdData, flagWrEn, flagWrData;
  logic [BLK_W-1:0] flagRdAddr, flagWrAddr;

  fbc_control #(
    .BLK_W(BLK_W), .IDX_W(IDX_W), .FULL_BURSTS(FULL_BURSTS)
  ) u_control (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqBlock(reqBlock),
    .rspValid(rspValid), .rspExpanded(rspExpanded),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memAddr(memAddr), .memRspValid(memRspValid),
    .uniformQ(uniformQ), .ctl(ctl), .burstIdx(burstIdx),
    .flagRdEn(flagRdEn), .flagRdAddr(flagRdAddr), .flagRdData(flagRdData),
    .flagWrEn(flagWrEn), .flagWrAddr(flagWrAddr), .flagWrData(flagWrData)
  );

  fbc_datapath #(
    .PIX(PIX), .SPP(SPP), .COLOR_W(COLOR_W), .DEPTH_W(DEPTH_W), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .burstIdx(burstIdx),
    .reqData(reqData), .memRspData(memRspData),
    .memWData(memWData), .rspData(rspData), .uniformQ(uniformQ)
  );

  fbc_flag_store #(
    .BLK_W(BLK_W)
  ) u_flags (
    .clk(clk), .rst_n(rst_n),
    .rdEn(flagRdEn), .rdAddr(flagRdAddr), .rdData(flagRdData),
    .wrEn(flagWrEn), .wrAddr(flagWrAddr), .wrData(flagWrData)
  );

endmodule

// File: tb/fb_block_compressor_bench.sv
module fb_block_compressor_bench;

  localparam int SW = 64;
  localparam int BW = 256;
  localparam int KW = 1024;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          reqValid, reqReady, reqWrite;
  logic [5:0]    reqBlock;
  logic [KW-1:0] reqData;
  logic          rspValid, rspExpanded;
  logic [KW-1:0] rspData;
  logic          memReqValid, memReqReady, memReqWrite;
  logic [7:0]    memAddr;
  logic [BW-1:0] memWData;
  logic          memRspValid;
  logic [BW-1:0] memRspData;

  fb_block_compressor u_fb_block_compressor (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBlock(reqBlock), .reqData(reqData),
    .rspValid(rspValid), .rspExpanded(rspExpanded), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memAddr(memAddr), .memWData(memWData),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Scoreboard queues.
  bit            eWr[$];
  int            eAddr[$];
  logic [BW-1:0] eData[$];
  string         eTag[$];
  bit            rExp[$];
  bit            rChk[$];
  logic [KW-1:0] rData[$];
  string         rTag[$];

  logic [KW-1:0] shadowData [64];
  bit            shadowFlag [64];
  logic [BW-1:0] mem [256];

  task automatic check(input bit ok, input string tag, input string msg);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic logic [SW-1:0] smp(input logic [KW-1:0] d, input int p, input int s);
    return d[(p*4+s)*SW +: SW];
  endfunction

  function automatic bit isUniform(input logic [KW-1:0] d);
    for (int p = 0; p < 4; p++)
      for (int s = 1; s < 4; s++)
        if (smp(d, p, s) != smp(d, p, 0)) return 0;
    return 1;
  endfunction

  function automatic logic [KW-1:0] mkBlock(input int seed, input bit mixed, input int pp, input int ss);
    logic [KW-1:0] d;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++) begin
        logic [31:0] col, dep;
        col = 32'(seed * 131 + p * 7 + 1);
        dep = 32'(seed * 977) ^ 32'(p << 12) ^ 32'h00C0_FFEE;
        if (mixed && p == pp && s == ss) col = col ^ 32'h1;
        d[(p*4+s)*SW +: SW] = {dep, col};
      end
    return d;
  endfunction

  task automatic doOp(input bit wr, input int blk, input logic [KW-1:0] d);
    if (wr) begin
      bit u;
      u = isUniform(d);
      if (u) begin
        logic [BW-1:0] w;
        for (int p = 0; p < 4; p++) w[p*SW +: SW] = smp(d, p, 0);
        eWr.push_back(1); eAddr.push_back(blk*4); eData.push_back(w); eTag.push_back("R2");
      end else begin
        for (int b = 0; b < 4; b++) begin
          eWr.push_back(1); eAddr.push_back(blk*4+b); eData.push_back(d[b*BW +: BW]); eTag.push_back("R3");
        end
      end
      shadowFlag[blk] = !u;
      shadowData[blk] = d;
      rExp.push_back(!u); rChk.push_back(0); rData.push_back('0); rTag.push_back("R4");
    end else begin
      int n;
      n = shadowFlag[blk] ? 4 : 1;
      for (int b = 0; b < n; b++) begin
        eWr.push_back(0); eAddr.push_back(blk*4+b); eData.push_back('0);
        eTag.push_back(shadowFlag[blk] ? "R6" : "R5");
      end
      rExp.push_back(shadowFlag[blk]); rChk.push_back(1); rData.push_back(shadowData[blk]);
      rTag.push_back(shadowFlag[blk] ? "R6" : "R5");
    end
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqBlock = 6'(blk); reqData = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    check(reqReady == 0, "R9", $sformatf("reqReady after accept act=%0b exp=0", reqReady));
  endtask

  // Memory model with random backpressure and read latency.
  initial begin
    bit rdPend = 0;
    int rdLat = 0;
    int rdAddr = 0;
    bit prevStall = 0;
    logic [7:0] stallAddr = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    memReqReady = 0; memRspValid = 0; memRspData = '0;
    forever begin
      @(negedge clk);
      memRspValid = 0;
      if (rdPend) begin
        if (rdLat == 0) begin
          memRspValid = 1; memRspData = mem[rdAddr]; rdPend = 0;
        end else rdLat--;
      end
      if (prevStall)
        check(memReqValid && memAddr == stallAddr, "R8",
              $sformatf("stalled request valid=%0b addr=%0d exp addr=%0d", memReqValid, memAddr, stallAddr));
      memReqReady = rst_n && (($urandom % 10) < 7);
      prevStall = memReqValid && !memReqReady;
      stallAddr = memAddr;
      if (memReqValid && memReqReady) begin
        check(!rdPend && !memRspValid, "R7", "request raised while a read is awaited act=1 exp=0");
        if (eAddr.size() == 0) begin
          check(0, "R2", $sformatf("unexpected burst addr=%0d", memAddr));
        end else begin
          bit xw; int xa; logic [BW-1:0] xd; string xt;
          xw = eWr.pop_front(); xa = eAddr.pop_front(); xd = eData.pop_front(); xt = eTag.pop_front();
          check(memReqWrite == xw && int'(memAddr) == xa, xt,
                $sformatf("burst wr/addr act=%0b/%0d exp=%0b/%0d", memReqWrite, memAddr, xw, xa));
          if (xw) check(memWData == xd, xt, $sformatf("burst data act=%h exp=%h", memWData, xd));
        end
        if (memReqWrite) mem[memAddr] = memWData;
        else begin
          rdPend = 1; rdLat = $urandom % 4; rdAddr = int'(memAddr);
        end
      end
    end
  end

  // Response monitor.
  initial begin
    bit lastRsp = 0;
    forever begin
      @(negedge clk);
      if (rspValid) begin
        check(!lastRsp, "R9", "completion pulse longer than one cycle act=2 exp=1");
        if (rExp.size() == 0) begin
          check(0, "R9", "unexpected completion act=1 exp=0");
        end else begin
          bit xe, xc; logic [KW-1:0] xd; string xt;
          xe = rExp.pop_front(); xc = rChk.pop_front(); xd = rData.pop_front(); xt = rTag.pop_front();
          check(rspExpanded == xe, "R4", $sformatf("%s state act=%0b exp=%0b", xt, rspExpanded, xe));
          if (xc) check(rspData == xd, xt, $sformatf("read data act=%h exp=%h", rspData, xd));
        end
      end
      lastRsp = rspValid;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R9", "watchdog expired act=hung exp=complete");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin shadowData[i] = '0; shadowFlag[i] = 0; end
    rst_n = 0; reqValid = 0; reqWrite = 0; reqBlock = '0; reqData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(reqReady == 1, "R1", $sformatf("reqReady act=%0b exp=1", reqReady));
    check(memReqValid == 0, "R1", $sformatf("memReqValid act=%0b exp=0", memReqValid));
    check(rspValid == 0, "R1", $sformatf("rspValid act=%0b exp=0", rspValid));

    // R10: never-written block reads as compressed
    doOp(0, 5, '0);
    // R2 then R5
    doOp(1, 5, mkBlock(3, 0, 0, 0));
    doOp(0, 5, '0);
    // R3 (last sample of last pixel differs), then R6
    doOp(1, 9, mkBlock(4, 1, 3, 3));
    doOp(0, 9, '0);
    // R4 collision: uniform overwrite followed at once by read of the same block
    doOp(1, 9, mkBlock(5, 0, 0, 0));
    doOp(0, 9, '0);
    // R4 collision the other way, at the top block index
    doOp(1, 63, mkBlock(6, 1, 0, 1));
    doOp(0, 63, '0);
    doOp(1, 0, mkBlock(7, 1, 1, 2));
    doOp(0, 0, '0);
    // Mixed traffic over a few blocks
    for (int k = 0; k < 30; k++) begin
      int blk;
      blk = int'($urandom % 8);
      if ($urandom % 2) doOp(1, blk, mkBlock(10 + k, ($urandom % 2) == 1, int'($urandom % 4), int'($urandom % 4)));
      else doOp(0, blk, '0);
      if ((k % 5) == 0) repeat (6) @(negedge clk);
    end

    while (eAddr.size() != 0 || rExp.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule